// File: doc/BRIEF.md
# DMA Operation Control Register

This block is the single 32-bit control and status word of a DMA controller, reached over a simple synchronous register bus. The bus has a select line, a write enable, a write data word and a read data word. Software uses it to turn transfers on and off. It also picks the channel-priority mode, switches between normal and on-demand transfer operation, and sets one more general mode bit.

The word also carries two sticky error flags: an address-error flag and an NMI flag. Hardware sets them through one-cycle pulse inputs. Software can never set them. A flag clears only through a handshake: a read must first return the flag as 1, and the next write to the register must then carry a 0 in that bit position. Any write ends the handshake, whatever it carries.

Two outputs go to the rest of the controller. The first is a transfers-permitted qualifier. The second is a bus-available pin whose polarity follows the on-demand mode bit.

Top module: `dma_opctl_reg`

## Requirements
- R1: After reset every bit of the word reads as 0, `xferOk` is 0 and both flags are clear.
- R2: Bits 31..16, 14..10, 7..5 and 3 always read as 0, whatever was written to them.
- R3: The fields on-demand (bit 15), priority mode (bits 9..8), mode bit (bit 4) and master enable (bit 0) take the written value on a write and read it back. They keep their value when no write occurs.
- R4: A one-cycle high on `aerrPulse` sets the address-error flag (bit 2). A one-cycle high on `nmiPulse` sets the NMI flag (bit 1).
- R5: Writing 1 to bit 2 or bit 1 never sets a flag.
- R6: Writing 0 to a set flag clears nothing unless a read has returned that flag as 1 since the last write.
- R7: A read that returns a flag as 1, followed by a write with 0 in that bit, clears the flag at the write's clock edge.
- R8: Any write disarms the handshake. After a read, a write carrying 1 in the flag's bit leaves the flag set, and a later write of 0 with no new read also leaves it set.
- R9: When a set pulse and a clearing write fall in the same cycle, the flag ends up set.
- R10: `busAvailPin` equals `busAvailIn` while bit 15 is 0 and equals its inverse while bit 15 is 1.
- R11: `xferOk` is 1 exactly when the master enable is 1 and both flags are 0.
- R12: During a read access (`sel`=1, `wrEn`=0), `rdData` shows the word in the same cycle; otherwise it is 0. A write changes the word and the outputs only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register select from the address decoder |
| wrEn | input | 1 | 1 = write access, 0 = read access while selected |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational |
| aerrPulse | input | 1 | Address-error set pulse |
| nmiPulse | input | 1 | NMI set pulse |
| busAvailIn | input | 1 | Bus-available condition, active high |
| busAvailPin | output | 1 | Bus-available pin, polarity set by bit 15 |
| xferOk | output | 1 | Transfers permitted |

## Verification
The hardest situation to reach from the ports is a flag that is set but has lost its arming. A read that shows the flag arms it and also reveals it, so the bench must insert a write between the read and the clearing write. It then shows through a second read that the 0 write did not clear the flag. The set-versus-clear race is reached by driving the set pulse and the clearing write in the same cycle, after an arming read. Every flag observation is a bus read, so the bench re-reads to confirm that a flag stayed set, and that re-read also re-arms it.

// File: rtl/dma_opctl_pkg.sv
package dma_opctl_pkg;
  localparam int REG_W       = 32;
  localparam int NUM_FLAGS   = 2;   // index 0: NMI flag, index 1: address error
  localparam int FLAG_LO     = 1;   // flag f lives at bit FLAG_LO+f
  localparam int BIT_EN      = 0;
  localparam int BIT_MODE    = 4;
  localparam int BIT_PRIO_LO = 8;
  localparam int PRIO_W      = 2;
  localparam int BIT_ODM     = 15;

  typedef struct packed {
    logic                 onDemand;
    logic [PRIO_W-1:0]    prio;
    logic                 modeBit;
    logic                 masterEn;
  } cfg_t;

  typedef struct packed {
    logic                 rdEn;
    logic                 cfgWr;
    logic [NUM_FLAGS-1:0] flagClr;
  } strobe_t;
endpackage

// File: rtl/dma_opctl_ctrl.sv
module dma_opctl_ctrl
  import dma_opctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sel,
  input  logic                 wrEn,
  input  logic [NUM_FLAGS-1:0] wrFlagBits,
  input  logic [NUM_FLAGS-1:0] flagQ,
  output strobe_t              strobe
);
  logic rdAcc;
  logic wrAcc;
  logic [NUM_FLAGS-1:0] armed;

  assign rdAcc = sel & ~wrEn;
  assign wrAcc = sel & wrEn;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_arm
    // Arming: a read that shows the flag as 1 arms it; any write disarms (R7, R8)
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  armed[f] <= 1'b0;
      else if (wrAcc)             armed[f] <= 1'b0;
      else if (rdAcc && flagQ[f]) armed[f] <= 1'b1;
    end

    assign strobe.flagClr[f] = wrAcc & armed[f] & ~wrFlagBits[f];

    // R8: a write always leaves the handshake disarmed
    a_r8_write_disarms: assert property (@(posedge clk) disable iff (!rstN)
      wrAcc |=> !armed[f]);
  end

  assign strobe.rdEn  = rdAcc;
  assign strobe.cfgWr = wrAcc;
endmodule

// File: rtl/dma_opctl_dp.sv
module dma_opctl_dp
  import dma_opctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  cfg_t                 wrCfg,
  input  logic [NUM_FLAGS-1:0] flagSet,
  input  logic                 busAvailIn,
  output logic [REG_W-1:0]     rdData,
  output logic                 busAvailPin,
  output logic                 xferOk,
  output logic [NUM_FLAGS-1:0] flagQ
);
  cfg_t cfgQ;
  logic [REG_W-1:0] word;

  // R3: configuration fields load only on a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgQ <= '0;
    else if (strobe.cfgWr) cfgQ <= wrCfg;
  end

  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cfgWr |=> $stable(cfgQ));

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    // R4, R9: set pulse takes priority over a clearing write
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  flagQ[f] <= 1'b0;
      else if (flagSet[f])        flagQ[f] <= 1'b1;
      else if (strobe.flagClr[f]) flagQ[f] <= 1'b0;
    end

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      flagSet[f] |=> flagQ[f]);
    a_r5_rise_needs_pulse: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagQ[f]) |-> $past(flagSet[f]));
  end

  always_comb begin
    word                            = '0;
    word[BIT_ODM]                   = cfgQ.onDemand;
    word[BIT_PRIO_LO +: PRIO_W]     = cfgQ.prio;
    word[BIT_MODE]                  = cfgQ.modeBit;
    word[BIT_EN]                    = cfgQ.masterEn;
    word[FLAG_LO +: NUM_FLAGS]      = flagQ;
  end

  // R12: combinational read, zero outside read accesses
  assign rdData      = strobe.rdEn ? word : '0;
  assign busAvailPin = busAvailIn ^ cfgQ.onDemand;   // R10
  assign xferOk      = cfgQ.masterEn & ~|flagQ;       // R11
endmodule

// File: rtl/dma_opctl_reg.sv
module dma_opctl_reg
  import dma_opctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sel,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             aerrPulse,
  input  logic             nmiPulse,
  input  logic             busAvailIn,
  output logic             busAvailPin,
  output logic             xferOk
);
  strobe_t              strobe;
  cfg_t                 wrCfg;
  logic [NUM_FLAGS-1:0] flagQ;
  logic                 unusedWr;

  assign wrCfg.onDemand = wrData[BIT_ODM];
  assign wrCfg.prio     = wrData[BIT_PRIO_LO +: PRIO_W];
  assign wrCfg.modeBit  = wrData[BIT_MODE];
  assign wrCfg.masterEn = wrData[BIT_EN];
  assign unusedWr       = ^wrData;

  dma_opctl_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sel        (sel),
    .wrEn       (wrEn),
    .wrFlagBits (wrData[FLAG_LO +: NUM_FLAGS]),
    .flagQ      (flagQ),
    .strobe     (strobe)
  );

  dma_opctl_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrCfg       (wrCfg),
    .flagSet     ({aerrPulse, nmiPulse}),
    .busAvailIn  (busAvailIn),
    .rdData      (rdData),
    .busAvailPin (busAvailPin),
    .xferOk      (xferOk),
    .flagQ       (flagQ)
  );

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_chk
    // R6, R7: a flag only falls after a write carrying 0 in its bit
    a_r7_fall_needs_zero_write: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flagQ[f]) |-> $past(sel && wrEn && !wrData[FLAG_LO+f]));
  end
endmodule

// File: tb/dma_opctl_reg_tb.sv
module dma_opctl_reg_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        aerrPulse = 1'b0;
  logic        nmiPulse = 1'b0;
  logic        busAvailIn = 1'b0;
  logic        busAvailPin;
  logic        xferOk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  dma_opctl_reg u_dut (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .aerrPulse(aerrPulse), .nmiPulse(nmiPulse),
    .busAvailIn(busAvailIn), .busAvailPin(busAvailPin), .xferOk(xferOk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wrEn = 1'b1; wrData = d;
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wrEn = 1'b0;
    #1 d = rdData;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic pulse(input logic aerr, input logic nmi);
    @(negedge clk);
    aerrPulse = aerr; nmiPulse = nmi;
    @(negedge clk);
    aerrPulse = 1'b0; nmiPulse = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 xferOk", {31'b0, xferOk}, 32'h0);
    readReg(d);
    check("R1 reset word", d, 32'h0);
  endtask

  task automatic testFields();
    logic [31:0] d;
    writeReg(32'hFFFF_FFFF);
    readReg(d);
    check("R2/R5 all-ones write", d, 32'h0000_8311);
    check("R11 enabled, no flags", {31'b0, xferOk}, 32'h1);
    writeReg(32'h0000_0210);
    readReg(d);
    check("R3 pattern 0x210", d, 32'h0000_0210);
    repeat (3) @(negedge clk);
    readReg(d);
    check("R3 hold without write", d, 32'h0000_0210);
    writeReg(32'h0000_8101);
    readReg(d);
    check("R3 pattern 0x8101", d, 32'h0000_8101);
  endtask

  task automatic testTiming();
    @(negedge clk);
    check("R12 idle rdData zero", rdData, 32'h0);
    writeReg(32'h0);
    @(negedge clk);
    sel = 1'b1; wrEn = 1'b1; wrData = 32'h1;
    #1 check("R12 write not yet applied", {31'b0, xferOk}, 32'h0);
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b0; wrData = '0;
    check("R12 write applied after edge", {31'b0, xferOk}, 32'h1);
  endtask

  task automatic testPolarity();
    writeReg(32'h0);
    busAvailIn = 1'b1; #1;
    check("R10 normal high", {31'b0, busAvailPin}, 32'h1);
    busAvailIn = 1'b0; #1;
    check("R10 normal low", {31'b0, busAvailPin}, 32'h0);
    writeReg(32'h0000_8000);
    busAvailIn = 1'b1; #1;
    check("R10 on-demand inverted high", {31'b0, busAvailPin}, 32'h0);
    busAvailIn = 1'b0; #1;
    check("R10 on-demand inverted low", {31'b0, busAvailPin}, 32'h1);
  endtask

  task automatic testFlagClear();
    logic [31:0] d;
    writeReg(32'h1);
    pulse(1'b1, 1'b0);
    check("R11 blocked by aerr", {31'b0, xferOk}, 32'h0);
    writeReg(32'h1);              // zero in bit 2, never read: no clear
    readReg(d);
    check("R6 unarmed write keeps aerr", d, 32'h0000_0005);
    writeReg(32'h1);              // armed by previous read
    readReg(d);
    check("R7 armed write clears aerr", d, 32'h0000_0001);
    check("R11 re-enabled", {31'b0, xferOk}, 32'h1);
    pulse(1'b0, 1'b1);
    readReg(d);
    check("R4 nmi set", d, 32'h0000_0003);
    writeReg(32'h0000_0003);      // write 1: no effect, disarms
    writeReg(32'h0000_0001);      // no new read: no clear
    readReg(d);
    check("R8 disarmed write keeps nmi", d, 32'h0000_0003);
    writeReg(32'h0000_0001);
    readReg(d);
    check("R7 nmi cleared", d, 32'h0000_0001);
  endtask

  task automatic testSetWins();
    logic [31:0] d;
    pulse(1'b1, 1'b0);
    readReg(d);
    check("R4 aerr set", d, 32'h0000_0005);
    @(negedge clk);
    sel = 1'b1; wrEn = 1'b1; wrData = 32'h0; aerrPulse = 1'b1;
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b0; aerrPulse = 1'b0;
    readReg(d);
    check("R9 set wins over clear", d, 32'h0000_0004);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFields();
    testTiming();
    testPolarity();
    testFlagClear();
    testSetWins();
    done = 1;
    finishRun();
  end
endmodule